// File: doc/BRIEF.md
# Configurable IO Pin Multiplexer

This block sits between a row of external IO cells and the peripheral functions of a chip. Each cell has a selection register that picks which function owns the pad. The selection steers the pad's output data, its output-enable and its input path together, so changing one register moves the whole signal to a different function. Selection value 0 gives the pad to its own GPIO line, and every cell comes out of reset as GPIO.

The shared peripheral functions come in three kinds, set per function by a parameter: input-only, output-only and bidirectional. A cell that selects value `s` (1 or more) is routed to shared function `(c + s - 1) mod N_PF`, where `c` is the cell index. Each cell therefore reaches a different rotation of the function set. A function input that no cell feeds is held at zero. If several cells claim the same function input, the lowest-numbered cell drives it.

The selection registers are reached through a plain address/data port. The cell index is taken from a fixed bit field of the address. An index that names no cell is flagged as an error. Routing is purely combinational; only the selection registers are clocked.

Top module: `pad_func_mux`

## Requirements
- R1: After reset every selection register reads 0, so each pad carries its GPIO function.
- R2: A cell with selection 0 drives `cell_out[c]` from `gpio_out[c]` and `cell_oe[c]` from `gpio_oe[c]`, and `gpio_in[c]` follows `cell_in[c]`.
- R3: `gpio_in[c]` is 0 whenever cell c has a nonzero selection.
- R4: A cell whose selection maps to an output-only function (kind code 1) drives that function's `pf_out` with `cell_oe` held at 1.
- R5: A cell whose selection maps to a bidirectional function (kind code 2) drives that function's `pf_out` and `pf_oe`, and feeds `cell_in` to the function's `pf_in`.
- R6: A cell whose selection maps to an input-only function (kind code 0) has `cell_out` and `cell_oe` at 0, and feeds `cell_in` to that function's `pf_in`. A function of kind code 3 is absent, and a cell selecting it drives 0 on both pins.
- R7: `pf_in[f]` is 0 when no cell selects function f, and always 0 for output-only or absent functions.
- R8: When several cells select the same function with an input, `pf_in[f]` follows the lowest-numbered such cell.
- R9: Nonzero selection s on cell c maps to shared function `(c + s - 1) mod N_PF`. Kind codes sit in `PF_KIND[2f+1:2f]`.
- R10: A write with `wr_en` to an address whose index field `addr[IDX_LO+IDX_W-1:IDX_LO]` is below N_CELLS stores `wdata[SEL_W-1:0]` into that cell's register. The new value routes from the next cycle, and `wr_err` is 0.
- R11: A write whose index field is N_CELLS or more changes no register and raises `wr_err` in the same cycle.
- R12: A read with `rd_en` at a valid index returns the selection zero-extended on `rd_data`, with `rd_err` 0. At an invalid index it returns `rd_err` 1 and `rd_data` 0. With `rd_en` low both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address; index in bits IDX_LO upward |
| wdata | input | DATA_W | Write data |
| wr_err | output | 1 | Write index names no cell |
| rd_data | output | DATA_W | Read data |
| rd_err | output | 1 | Read index names no cell |
| cell_in | input | N_CELLS | Pad input level from each cell |
| cell_out | output | N_CELLS | Output data to each cell |
| cell_oe | output | N_CELLS | Output-enable to each cell |
| gpio_in | output | N_CELLS | Input to each cell's GPIO function |
| gpio_out | input | N_CELLS | Output from each cell's GPIO function |
| gpio_oe | input | N_CELLS | Output-enable from each cell's GPIO function |
| pf_in | output | N_PF | Input to each shared function |
| pf_out | input | N_PF | Output from each shared function |
| pf_oe | input | N_PF | Output-enable from each shared function |

## Verification
The bench walks through every combination of selections on the four cells and drives several input patterns for each. This covers every mapping of cell and selection onto function, and every way cells can collide on one function. A design that gave contention to the highest cell, or that let an output-only function's input float to the pad level, would disagree with the computed `pf_in`. A design that routed data but left the enable on the GPIO path would show up on `cell_oe`. Port cases check out-of-range indices, which must leave the registers alone and must not alias onto a low cell. They also check write data wider than the field, which must be truncated to the field width.

// File: rtl/pad_func_mux.sv
module pad_func_mux #(
  parameter int N_CELLS = 4,
  parameter int N_PF    = 4,
  parameter int SEL_W   = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_LO  = 2,
  parameter int IDX_W   = 4,
  parameter logic [2*N_PF-1:0] PF_KIND = 8'b10_00_01_10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               wr_err,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_err,
  input  logic [N_CELLS-1:0] cell_in,
  output logic [N_CELLS-1:0] cell_out,
  output logic [N_CELLS-1:0] cell_oe,
  output logic [N_CELLS-1:0] gpio_in,
  input  logic [N_CELLS-1:0] gpio_out,
  input  logic [N_CELLS-1:0] gpio_oe,
  output logic [N_PF-1:0]    pf_in,
  input  logic [N_PF-1:0]    pf_out,
  input  logic [N_PF-1:0]    pf_oe
);
  localparam int NCH = 1 << SEL_W;

  function automatic logic [NCH-1:0] fmask(int c, int f);
    logic [NCH-1:0] m;
    m = '0;
    for (int s = 1; s < NCH; s++)
      if ((c + s - 1) % N_PF == f) m[s] = 1'b1;
    return m;
  endfunction

  logic [SEL_W-1:0]  sel_q [N_CELLS];
  logic [IDX_W-1:0]  a_idx;
  logic [N_CELLS-1:0] ahit;
  logic              a_ok;
  logic [SEL_W-1:0]  rd_pick;
  logic [N_PF-1:0]   want [N_CELLS];

  assign a_idx  = addr[IDX_LO +: IDX_W];
  assign a_ok   = |ahit;
  assign wr_err = wr_en & ~a_ok;
  assign rd_err = rd_en & ~a_ok;

  always_comb begin
    rd_pick = '0;
    for (int c = 0; c < N_CELLS; c++)
      if (ahit[c]) rd_pick = sel_q[c];
  end

  assign rd_data = (rd_en && a_ok) ? {{(DATA_W-SEL_W){1'b0}}, rd_pick} : '0;

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [NCH-1:0] opt_o, opt_e, hit_s;

    assign ahit[c] = (a_idx == IDX_W'(c));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 sel_q[c] <= '0;
      else if (wr_en && ahit[c])  sel_q[c] <= wdata[SEL_W-1:0];

    assign opt_o[0] = gpio_out[c];
    assign opt_e[0] = gpio_oe[c];
    assign hit_s[0] = (sel_q[c] == '0);

    for (genvar s = 1; s < NCH; s++) begin : g_ch
      localparam int F = (c + s - 1) % N_PF;
      localparam logic [1:0] K = PF_KIND[2*F +: 2];
      assign hit_s[s] = (sel_q[c] == SEL_W'(s));
      assign opt_o[s] = (K == 2'd1 || K == 2'd2) ? pf_out[F] : 1'b0;
      assign opt_e[s] = (K == 2'd1) ? 1'b1 : (K == 2'd2) ? pf_oe[F] : 1'b0;

      if (K == 2'd0) begin : g_inonly
        // R6
        input_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
          sel_q[c] == SEL_W'(s) |-> !cell_oe[c] && !cell_out[c]);
      end
      if (K == 2'd1) begin : g_outonly
        // R4
        output_only_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
          sel_q[c] == SEL_W'(s) |-> cell_oe[c] && cell_out[c] == pf_out[F]);
      end
    end

    for (genvar f = 0; f < N_PF; f++) begin : g_want
      localparam logic [NCH-1:0] M = fmask(c, f);
      assign want[c][f] = |(hit_s & M);
    end

    assign cell_out[c] = opt_o[sel_q[c]];
    assign cell_oe[c]  = opt_e[sel_q[c]];
    assign gpio_in[c]  = cell_in[c] & hit_s[0];

    // R3
    gpio_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[c] != '0 |-> !gpio_in[c]);
    // R10
    sel_write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && ahit[c] |=> sel_q[c] == $past(wdata[SEL_W-1:0]));
    // R11
    sel_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !a_ok |=> $stable(sel_q[c]));
  end

  for (genvar f = 0; f < N_PF; f++) begin : g_pf
    localparam logic [1:0] K = PF_KIND[2*f +: 2];
    logic v;
    always_comb begin
      v = 1'b0;
      for (int c = N_CELLS - 1; c >= 0; c--)
        if (want[c][f]) v = cell_in[c];
    end
    assign pf_in[f] = (K == 2'd0 || K == 2'd2) ? v : 1'b0;

    if (K == 2'd1 || K == 2'd3) begin : g_noin
      // R7
      pf_in_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_in[f]);
    end
  end

  // R12
  rd_bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !a_ok |-> rd_err && rd_data == '0);
  // R12
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:SEL_W] == '0);
endmodule

// File: tb/test_pad_func_mux.sv
module test_pad_func_mux;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic wr_err, rd_err;
  logic [31:0] rd_data;
  logic [3:0] cell_in = 0, cell_out, cell_oe, gpio_in, gpio_out = 0, gpio_oe = 0;
  logic [3:0] pf_in, pf_out = 0, pf_oe = 0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pad_func_mux i_pad_func_mux (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .wr_err, .rd_data, .rd_err,
    .cell_in, .cell_out, .cell_oe, .gpio_in, .gpio_out, .gpio_oe,
    .pf_in, .pf_out, .pf_oe);

  // kinds: f0 bidir, f1 output-only, f2 input-only, f3 bidir
  function automatic int kind(int f);
    case (f) 0: return 2; 1: return 1; 2: return 0; default: return 2; endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d, logic exp_err, string req);
    @(negedge clk);
    wr_en = 1; addr = 8'(idx << 2); wdata = d;
    #1 chk(req, 32'(wr_err), 32'(exp_err));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int idx, logic [31:0] exp_d, logic exp_err, string req);
    @(negedge clk);
    rd_en = 1; addr = 8'(idx << 2);
    #1 chk(req, rd_data, exp_d);
    chk(req, 32'(rd_err), 32'(exp_err));
    rd_en = 0;
  endtask

  task automatic route(int sel [4], logic [31:0] p);
    logic [3:0] eo, ee, eg, ep;
    @(negedge clk);
    cell_in = p[3:0]; gpio_out = p[7:4]; gpio_oe = p[11:8];
    pf_out = p[15:12]; pf_oe = p[19:16];
    #1;
    eo = 0; ee = 0; eg = 0; ep = 0;
    for (int c = 0; c < 4; c++) begin
      if (sel[c] == 0) begin
        eo[c] = gpio_out[c]; ee[c] = gpio_oe[c]; eg[c] = cell_in[c];
      end else begin
        int f = (c + sel[c] - 1) % 4;
        int k = kind(f);
        if (k == 1) begin eo[c] = pf_out[f]; ee[c] = 1; end
        if (k == 2) begin eo[c] = pf_out[f]; ee[c] = pf_oe[f]; end
      end
    end
    for (int f = 0; f < 4; f++) begin
      bit done = 0;
      if (kind(f) == 0 || kind(f) == 2)
        for (int c = 0; c < 4; c++)
          if (!done && sel[c] != 0 && (c + sel[c] - 1) % 4 == f) begin
            ep[f] = cell_in[c]; done = 1;
          end
    end
    chk("R2/R4/R5/R6/R9 cell_out", 32'(cell_out), 32'(eo));
    chk("R2/R4/R5/R6 cell_oe", 32'(cell_oe), 32'(ee));
    chk("R2/R3 gpio_in", 32'(gpio_in), 32'(eg));
    chk("R5/R6/R7/R8 pf_in", 32'(pf_in), 32'(ep));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int zs [4] = '{0, 0, 0, 0};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    for (int c = 0; c < 4; c++) rd(c, 0, 0, "R1 reset read");
    route(zs, 32'h000A5C3);
    route(zs, 32'h00F3A5C);
    // R12 idle read port
    @(negedge clk); #1 chk("R12 idle rd_data", rd_data, 0);
    chk("R12 idle rd_err", 32'(rd_err), 0);
    // R10 truncation
    wr(1, 32'hFFFF_FFFD, 0, "R10 wr_err valid");
    rd(1, 32'h1, 0, "R10/R12 truncated read");
    // R11 invalid write leaves all cells
    wr(4, 32'h3, 1, "R11 wr_err");
    wr(15, 32'h2, 1, "R11 wr_err high");
    for (int c = 0; c < 4; c++) rd(c, (c == 1) ? 1 : 0, 0, "R11 no change");
    // R12 invalid read
    rd(5, 0, 1, "R12 bad index");
    rd(12, 0, 1, "R12 bad index high");
    // exhaustive selections: R2-R9
    for (int combo = 0; combo < 256; combo++) begin
      int sel [4];
      for (int c = 0; c < 4; c++) begin
        sel[c] = (combo >> (2 * c)) & 3;
        wr(c, 32'(sel[c]) | 32'hABCD_0000, 0, "R10 wr_err sweep");
      end
      for (int k = 0; k < 3; k++)
        route(sel, 32'(combo * 40503 + k * 2654435) ^ 32'h5A3C9);
      if (combo % 37 == 0)
        for (int c = 0; c < 4; c++) rd(c, 32'(sel[c]), 0, "R10/R12 sweep read");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule